// File: doc/BRIEF.md
# Register-Ready Replay Check Stage

This stage sits between a dynamic scheduler and register read. Every instruction the scheduler issues passes through it. The stage looks up both source registers in a table of per-register ready flags. An instruction whose operands are both available leaves the stage as replay-safe and goes on to register read and execution. An instruction with a missing operand, typically the consumer of a load whose latency was predicted too short, does not go back to the scheduler. It keeps its computed slot order and waits in a small timed queue outside the window. After a fixed extra delay it is checked again.

Because recovery never touches the scheduler window, the window keeps no ancestry information and can free an entry the moment it issues. While the queue holds anything, the stage raises a stop line to the scheduler. Queued instructions take priority over fresh issues when they become due. The ready table is cleared for a destination when its producer issues, and set again by the writeback port.

Top module: `replay_check_stage`

## Requirements
- R1: After reset every register is marked ready, the replay queue is empty, and both the stop output and the replay-safe output are low.
- R2: An instruction whose two sources are both ready passes its check. One cycle after the check, the replay-safe output is high and carries that instruction's source and destination fields.
- R3: An instruction with either source not ready does not raise replay-safe. It enters the replay queue. The stop output goes high in the cycle after the failed check and stays high for as long as the queue is non-empty. The scheduler holds issue while stop is high, and under that rule the queue never holds more than DEPTH entries.
- R4: A failed instruction is checked again exactly DELAY+1 cycles after its failed check, with no scheduler involvement.
- R5: When the queue head is due, it is checked in place of a new issue. A new issue arriving in that cycle is placed at the queue tail with no extra wait, so it is checked in the next free slot.
- R6: A replayed instruction that fails again goes back to the queue tail, behind anything queued after it, with a fresh DELAY wait.
- R7: A writeback to a source register in the same cycle that the register is checked counts as ready (bypass).
- R8: A writeback sets the register's ready flag. An issue clears the ready flag of its destination. When both hit the same register in the same cycle, the clear wins.
- R9: The replay-safe output carries a flag that is 1 when the instruction came out of the replay queue and 0 when it came straight from issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_src_a | input | $clog2(NREGS) | First source register |
| iss_src_b | input | $clog2(NREGS) | Second source register |
| iss_dst | input | $clog2(NREGS) | Destination register (its ready flag is cleared) |
| wb_valid | input | 1 | Writeback this cycle |
| wb_reg | input | $clog2(NREGS) | Register made ready by the writeback |
| stall_sched | output | 1 | Stop request to the scheduler; high while the replay queue is non-empty |
| safe_valid | output | 1 | An instruction passed its check (registered) |
| safe_src_a | output | $clog2(NREGS) | First source of the passing instruction |
| safe_src_b | output | $clog2(NREGS) | Second source of the passing instruction |
| safe_dst | output | $clog2(NREGS) | Destination of the passing instruction |
| safe_replayed | output | 1 | Passing instruction came from the replay queue |

## Verification
The check itself is combinational in the cycle an instruction is picked, and the replay-safe result is due one edge later. The stop output follows the queue occupancy and also changes on the edge that ends a failed check. A failed instruction's second check happens DELAY+1 cycles after its first, and a second failure pushes its pass out to 2*(DELAY+1). The bench drives stimulus just after a falling edge, steps one full cycle, and compares outputs at the next falling edge. The expected pass cycle for each case is computed from DELAY and the cycle in which the bench places the writeback. Every cycle in between is checked for the absence of a pass and for a high stop output.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   // Source of the instruction examined by the check stage in a cycle.
   typedef enum logic [1:0] {
      PICK_NONE  = 2'd0,
      PICK_QUEUE = 2'd1,
      PICK_ISSUE = 2'd2
   } pick_e;

   // Index width for a count of n items, never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/rcs_ready_table.sv
module rcs_ready_table #(
   parameter int NREGS  = 32,
   parameter int REG_W  = 5,
   parameter bit BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wb_valid,
   input  logic [REG_W-1:0] wb_reg,
   input  logic             clr_valid,
   input  logic [REG_W-1:0] clr_reg,
   input  logic [REG_W-1:0] rd_a,
   input  logic [REG_W-1:0] rd_b,
   output logic             ok_a,
   output logic             ok_b,
   output logic [NREGS-1:0] ready_q
);

   // One flag per register: the issue-time clear takes precedence over writeback.
   for (genvar g = 0; g < NREGS; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            ready_q[g] <= 1'b1;
         else if (clr_valid && clr_reg == REG_W'(g))
            ready_q[g] <= 1'b0;
         else if (wb_valid && wb_reg == REG_W'(g))
            ready_q[g] <= 1'b1;
      end
   end

   if (BYPASS) begin : g_bypass
      assign ok_a = ready_q[rd_a] | (wb_valid && wb_reg == rd_a);
      assign ok_b = ready_q[rd_b] | (wb_valid && wb_reg == rd_b);
   end else begin : g_plain
      assign ok_a = ready_q[rd_a];
      assign ok_b = ready_q[rd_b];
   end

endmodule

// File: rtl/rcs_replay_queue.sv
module rcs_replay_queue #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 15,
   parameter int TMR_W  = 2,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_a,
   input  logic [DATA_W-1:0] push_a_data,
   input  logic [TMR_W-1:0]  push_a_wait,
   input  logic              push_b,
   input  logic [DATA_W-1:0] push_b_data,
   input  logic [TMR_W-1:0]  push_b_wait,
   input  logic              pop,
   output logic              head_ready,
   output logic [DATA_W-1:0] head_data,
   output logic [CNT_W-1:0]  count,
   output logic              nonempty
);

   localparam int PTR_W = rcs_pkg::idx_w(DEPTH);

   logic [DATA_W-1:0] data_q [DEPTH];
   logic [TMR_W-1:0]  tmr_q  [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, slot_b;
   logic [CNT_W-1:0]  cnt_q;

   // Second push lands behind the first when both occur in one cycle.
   assign slot_b = push_a ? wr_ptr + PTR_W'(1) : wr_ptr;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[e] <= '0;
            tmr_q[e]  <= '0;
         end else if (push_a && wr_ptr == PTR_W'(e)) begin
            data_q[e] <= push_a_data;
            tmr_q[e]  <= push_a_wait;
         end else if (push_b && slot_b == PTR_W'(e)) begin
            data_q[e] <= push_b_data;
            tmr_q[e]  <= push_b_wait;
         end else if (tmr_q[e] != '0) begin
            tmr_q[e]  <= tmr_q[e] - TMR_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         rd_ptr <= rd_ptr + PTR_W'(pop);
         wr_ptr <= wr_ptr + PTR_W'(push_a) + PTR_W'(push_b);
         cnt_q  <= cnt_q + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop);
      end
   end

   assign nonempty   = (cnt_q != '0);
   assign head_ready = nonempty && (tmr_q[rd_ptr] == '0);
   assign head_data  = data_q[rd_ptr];
   assign count      = cnt_q;

endmodule

// File: rtl/replay_check_stage.sv
module replay_check_stage
   import rcs_pkg::*;
#(
   parameter int NREGS  = 32,
   parameter int DEPTH  = 4,
   parameter int DELAY  = 2,
   parameter bit BYPASS = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       iss_valid,
   input  logic [$clog2(NREGS)-1:0]   iss_src_a,
   input  logic [$clog2(NREGS)-1:0]   iss_src_b,
   input  logic [$clog2(NREGS)-1:0]   iss_dst,
   input  logic                       wb_valid,
   input  logic [$clog2(NREGS)-1:0]   wb_reg,
   output logic                       stall_sched,
   output logic                       safe_valid,
   output logic [$clog2(NREGS)-1:0]   safe_src_a,
   output logic [$clog2(NREGS)-1:0]   safe_src_b,
   output logic [$clog2(NREGS)-1:0]   safe_dst,
   output logic                       safe_replayed
);

   localparam int REG_W  = $clog2(NREGS);
   localparam int INST_W = 3 * REG_W;
   localparam int TMR_W  = $clog2(DELAY + 1);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("NREGS must be a power of two of at least 2");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DELAY < 1) begin : g_bad_delay
      $error("DELAY must be at least 1");
   end

   pick_e             pick;
   logic              from_queue;
   logic              head_ready, q_nonempty;
   logic [INST_W-1:0] head_data, iss_word, cand_word;
   logic [CNT_W-1:0]  q_count;
   logic [REG_W-1:0]  cand_src_a, cand_src_b, cand_dst;
   logic              cand_valid, ok_a, ok_b, cand_ok;
   logic [NREGS-1:0]  ready_q;
   logic              push_fail, push_defer;

   // A due replay entry always wins the single check slot.
   always_comb begin
      if (head_ready)     pick = PICK_QUEUE;
      else if (iss_valid) pick = PICK_ISSUE;
      else                pick = PICK_NONE;
   end

   assign from_queue = (pick == PICK_QUEUE);
   assign cand_valid = (pick != PICK_NONE);
   assign iss_word   = {iss_src_a, iss_src_b, iss_dst};
   assign cand_word  = from_queue ? head_data : iss_word;
   assign {cand_src_a, cand_src_b, cand_dst} = cand_word;

   rcs_ready_table #(
      .NREGS  (NREGS),
      .REG_W  (REG_W),
      .BYPASS (BYPASS)
   ) i_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wb_valid  (wb_valid),
      .wb_reg    (wb_reg),
      .clr_valid (iss_valid),
      .clr_reg   (iss_dst),
      .rd_a      (cand_src_a),
      .rd_b      (cand_src_b),
      .ok_a      (ok_a),
      .ok_b      (ok_b),
      .ready_q   (ready_q)
   );

   assign cand_ok    = ok_a && ok_b;
   assign push_fail  = cand_valid && !cand_ok;
   assign push_defer = from_queue && iss_valid;

   rcs_replay_queue #(
      .DEPTH  (DEPTH),
      .DATA_W (INST_W),
      .TMR_W  (TMR_W),
      .CNT_W  (CNT_W)
   ) i_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_a      (push_fail),
      .push_a_data (cand_word),
      .push_a_wait (TMR_W'(DELAY)),
      .push_b      (push_defer),
      .push_b_data (iss_word),
      .push_b_wait ('0),
      .pop         (from_queue),
      .head_ready  (head_ready),
      .head_data   (head_data),
      .count       (q_count),
      .nonempty    (q_nonempty)
   );

   assign stall_sched = q_nonempty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         safe_valid    <= 1'b0;
         safe_src_a    <= '0;
         safe_src_b    <= '0;
         safe_dst      <= '0;
         safe_replayed <= 1'b0;
      end else begin
         safe_valid    <= cand_valid && cand_ok;
         safe_src_a    <= cand_src_a;
         safe_src_b    <= cand_src_b;
         safe_dst      <= cand_dst;
         safe_replayed <= from_queue;
      end
   end

endmodule

// File: rtl/replay_check_stage_sva.sv
module replay_check_stage_sva #(
   parameter int NREGS = 32,
   parameter int DEPTH = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     iss_valid,
   input logic [$clog2(NREGS)-1:0] iss_dst,
   input logic                     wb_valid,
   input logic [$clog2(NREGS)-1:0] wb_reg,
   input logic                     stall_sched,
   input logic                     safe_valid,
   input logic                     cand_valid,
   input logic                     cand_ok,
   input logic [$clog2(NREGS)-1:0] cand_src_a,
   input logic [$clog2(NREGS)-1:0] cand_src_b,
   input logic                     head_ready,
   input logic                     from_queue,
   input logic [$clog2(DEPTH+1)-1:0] q_count,
   input logic [NREGS-1:0]         ready_q
);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= ($clog2(DEPTH+1))'(DEPTH));

   p_fail_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && !cand_ok) |=> (stall_sched && !safe_valid));

   p_pass_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && cand_ok) |=> safe_valid);

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cand_valid |=> !safe_valid);

   p_replay_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      head_ready |-> from_queue);

   p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && wb_valid && wb_reg == cand_src_a && wb_reg == cand_src_b) |-> cand_ok);

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> !ready_q[$past(iss_dst)]);

   p_wb_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !(iss_valid && iss_dst == wb_reg)) |=> ready_q[$past(wb_reg)]);

endmodule

bind replay_check_stage replay_check_stage_sva #(
   .NREGS (NREGS),
   .DEPTH (DEPTH)
) i_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .iss_valid   (iss_valid),
   .iss_dst     (iss_dst),
   .wb_valid    (wb_valid),
   .wb_reg      (wb_reg),
   .stall_sched (stall_sched),
   .safe_valid  (safe_valid),
   .cand_valid  (cand_valid),
   .cand_ok     (cand_ok),
   .cand_src_a  (cand_src_a),
   .cand_src_b  (cand_src_b),
   .head_ready  (head_ready),
   .from_queue  (from_queue),
   .q_count     (q_count),
   .ready_q     (ready_q)
);

// File: tb/test_replay_check_stage.sv
module test_replay_check_stage;

   localparam int NREGS = 32;
   localparam int DEPTH = 4;
   localparam int DELAY = 2;
   localparam int RW    = $clog2(NREGS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          iss_valid = 1'b0;
   logic [RW-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
   logic          wb_valid = 1'b0;
   logic [RW-1:0] wb_reg = '0;
   logic          stall_sched, safe_valid, safe_replayed;
   logic [RW-1:0] safe_src_a, safe_src_b, safe_dst;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   replay_check_stage #(.NREGS(NREGS), .DEPTH(DEPTH), .DELAY(DELAY), .BYPASS(1'b1)) i_replay_check_stage (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
      .wb_valid(wb_valid), .wb_reg(wb_reg),
      .stall_sched(stall_sched), .safe_valid(safe_valid),
      .safe_src_a(safe_src_a), .safe_src_b(safe_src_b), .safe_dst(safe_dst),
      .safe_replayed(safe_replayed)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic issue(input int a, input int b, input int d);
      iss_valid = 1'b1;
      iss_src_a = RW'(a);
      iss_src_b = RW'(b);
      iss_dst   = RW'(d);
   endtask

   task automatic expect_out(input string tag, input bit v, input int dst, input bit rep, input bit st);
      chk(tag, "safe_valid", int'(safe_valid), int'(v));
      if (v) begin
         chk(tag, "safe_dst", int'(safe_dst), dst);
         chk("R9", "safe_replayed", int'(safe_replayed), int'(rep));
      end
      chk("R3", "stall_sched", int'(stall_sched), int'(st));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: quiet outputs after reset
      expect_out("R1", 1'b0, 0, 1'b0, 1'b0);

      // Sweep every register: producer clears it, consumer fails, writeback
      // timing picks plain replay (R4), bypass (R7) or a double fail (R6).
      for (int r = 0; r < NREGS; r++) begin
         int o, v, wb_at, pass_at;
         string tag;
         o = (r + 5) % NREGS;
         issue(r, r, r);
         step();
         // R1 flags ready from reset, R2 pass one cycle after check
         expect_out("R2", 1'b1, r, 1'b0, 1'b0);
         chk("R2", "safe_src_a", int'(safe_src_a), r);
         if (r % 2 == 0) issue(r, o, r); else issue(o, r, r);
         step();
         iss_valid = 1'b0;
         // R8 producer cleared r, so the consumer fails
         expect_out("R8", 1'b0, 0, 1'b0, 1'b1);
         v = r % 3;
         wb_at   = (v == 0) ? 1 : (v == 1) ? DELAY + 1 : DELAY + 2;
         pass_at = (v == 2) ? 2 * (DELAY + 1) : DELAY + 1;
         tag     = (v == 0) ? "R4" : (v == 1) ? "R7" : "R6";
         for (int k = 1; k <= pass_at; k++) begin
            wb_valid = (k == wb_at);
            wb_reg   = RW'(r);
            step();
            expect_out(tag, k == pass_at, r, 1'b1, k < pass_at);
            if (k == pass_at) begin
               chk(tag, "safe_src_a", int'(safe_src_a), (r % 2 == 0) ? r : o);
               chk(tag, "safe_src_b", int'(safe_src_b), (r % 2 == 0) ? o : r);
            end
         end
         wb_valid = 1'b0;
      end

      // R5: new issue arriving when the head is due is deferred one slot
      issue(10, 10, 3);
      step();
      expect_out("R2", 1'b1, 3, 1'b0, 1'b0);
      issue(3, 10, 11);
      step();
      iss_valid = 1'b0;
      expect_out("R3", 1'b0, 0, 1'b0, 1'b1);
      for (int k = 1; k <= DELAY + 2; k++) begin
         wb_valid = (k == 1);
         wb_reg   = RW'(3);
         if (k == DELAY + 1) issue(12, 12, 13);
         step();
         iss_valid = 1'b0;
         if (k <= DELAY)          expect_out("R5", 1'b0, 0, 1'b0, 1'b1);
         else if (k == DELAY + 1) expect_out("R5", 1'b1, 11, 1'b1, 1'b1);
         else                     expect_out("R5", 1'b1, 13, 1'b1, 1'b0);
      end
      wb_valid = 1'b0;

      // R6: a re-failed head goes behind a later failed instruction
      issue(20, 20, 1);
      step();
      expect_out("R2", 1'b1, 1, 1'b0, 1'b0);
      issue(20, 20, 2);
      step();
      expect_out("R2", 1'b1, 2, 1'b0, 1'b0);
      issue(1, 20, 21);
      step();
      iss_valid = 1'b0;
      expect_out("R3", 1'b0, 0, 1'b0, 1'b1);
      for (int k = 1; k <= 2 * (DELAY + 1); k++) begin
         if (k == 1) issue(2, 20, 22);
         wb_valid = (k == DELAY || k == DELAY + 3);
         wb_reg   = (k == DELAY) ? RW'(2) : RW'(1);
         step();
         iss_valid = 1'b0;
         if (k == DELAY + 2)             expect_out("R6", 1'b1, 22, 1'b1, 1'b1);
         else if (k == 2 * (DELAY + 1))  expect_out("R6", 1'b1, 21, 1'b1, 1'b0);
         else                            expect_out("R6", 1'b0, 0, 1'b0, 1'b1);
      end
      wb_valid = 1'b0;

      // R8: clear beats writeback to the same register in one cycle
      issue(20, 20, 7);
      wb_valid = 1'b1;
      wb_reg   = RW'(7);
      step();
      wb_valid = 1'b0;
      expect_out("R8", 1'b1, 7, 1'b0, 1'b0);
      issue(7, 7, 8);
      step();
      iss_valid = 1'b0;
      expect_out("R8", 1'b0, 0, 1'b0, 1'b1);
      for (int k = 1; k <= DELAY + 1; k++) begin
         wb_valid = (k == 1);
         wb_reg   = RW'(7);
         step();
         expect_out("R8", k == DELAY + 1, 8, 1'b1, k < DELAY + 1);
      end
      wb_valid = 1'b0;

      // R2: back-to-back passing issues from straight issue
      for (int k = 0; k < 4; k++) begin
         issue(16 + k, 24 + k, 16 + k);
         step();
         expect_out("R2", 1'b1, 16 + k, 1'b0, 1'b0);
      end
      iss_valid = 1'b0;
      step();
      expect_out("R2", 1'b0, 0, 1'b0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule